// File: doc/BRIEF.md
# Multi-Tap Resynchronized Clock Divider

This block divides a primary clock down to much lower rates. A free-running binary counter advances on every primary clock edge while the block is enabled. Two output ports each pick one of four fixed counter taps. The four taps give division ratios of 16, 512, 16384 and 524288. The two selections are independent, so any two rates can be in use at once. Both ports may also pick the same rate.

A tap is never driven straight from the counter. Each selected tap is sampled into a flip-flop on the primary clock, so every port output changes exactly on a primary edge and is free of glitches. A registered copy of the enable is also provided as a "primary" output, which marks the undivided rate. When the enable is low, the counter is cleared and held. The tap outputs then stay low until the block is enabled again.

Top module: `divtap_top`

## Requirements
- R1: While rst_n is low, the counter and all outputs (primeOut, tapOutA, tapOutB) are 0.
- R2: With select 2'b00, a port output has a period of 16 primary cycles: 8 cycles high, then 8 cycles low.
- R3: With select 2'b01, a port output has a period of 512 cycles: 256 high, then 256 low.
- R4: With select 2'b10, a port output has a period of 16384 cycles: 8192 high, then 8192 low.
- R5: With select 2'b11, a port output has a period of 524288 cycles (262144 high, 262144 low). The first high level comes no earlier than 262144 enabled cycles after the counter starts.
- R6: The selects selA and selB act independently. When both hold the same value, tapOutA and tapOutB are identical.
- R7: A change on a select is reflected at the port output at the first primary clock edge after the change.
- R8: While enable is low, the counter is cleared, and both tap outputs are 0 from the next edge onward and do not toggle.
- R9: primeOut equals enable delayed by one primary clock edge.
- R10: Once enabled from a cleared state, a port with select 2'b00 is low for exactly 8 sampled cycles before its first high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Primary clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low clears and holds the divider |
| selA | input | 2 | Tap select for port A (00 /16, 01 /512, 10 /16384, 11 /524288) |
| selB | input | 2 | Tap select for port B, same encoding |
| primeOut | output | 1 | Registered enable, marking the undivided rate |
| tapOutA | output | 1 | Resynchronized divided waveform, port A |
| tapOutB | output | 1 | Resynchronized divided waveform, port B |

## Verification
A wrong counter value or a wrong tap mapping appears at the ports as a wrong high time, a wrong low time, or an offset first edge. With select 00, the bench sees this within the first 16 cycles after enable. At the coarser taps it shows up after at most one half-period. A stuck or missing resync register shows as a one-cycle shift: the first-rise offset is off by one, or the output lags a select change by one cycle. A counter that is not cleared on disable shows as toggling or an early rise after re-enable. Because the longest tap cannot run a full period in the allowed cycles, a second instance with a shortened top tap checks the mechanism for select 11. The full-size instance is checked for staying low.

// File: rtl/divtap_pkg.sv
package divtap_pkg;

  localparam int NUM_TAPS  = 4;
  localparam int SEL_W     = $clog2(NUM_TAPS);
  localparam int NUM_PORTS = 2;

  typedef logic [SEL_W-1:0] tapSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;   // advance the divider this edge
    logic clear;     // zero the divider and the port registers
  } divStrobe_t;

endpackage

// File: rtl/divtap_ctrl.sv
module divtap_ctrl
  import divtap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  output divStrobe_t stb,
  output logic       primeOut
);

  always_comb begin
    stb.countEn = enable;
    stb.clear   = ~enable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primeOut <= 1'b0;
    else        primeOut <= enable;
  end

  // R9: an idle enable drops the primary marker at the next edge
  assert_prime_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !primeOut);

endmodule

// File: rtl/divtap_datapath.sv
module divtap_datapath
  import divtap_pkg::*;
#(
  parameter int TAP_EXP0 = 4,
  parameter int TAP_EXP1 = 9,
  parameter int TAP_EXP2 = 14,
  parameter int TAP_EXP3 = 19
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  divStrobe_t                    stb,
  input  tapSel_t [NUM_PORTS-1:0]       portSel,
  output logic    [NUM_PORTS-1:0]       tapOut
);

  localparam int CNT_W = TAP_EXP3;

  function automatic int tapBit(input int idx);
    case (idx)
      0:       return TAP_EXP0 - 1;
      1:       return TAP_EXP1 - 1;
      2:       return TAP_EXP2 - 1;
      default: return TAP_EXP3 - 1;
    endcase
  endfunction

  logic [CNT_W-1:0]    divCnt;
  logic [NUM_TAPS-1:0] tapVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           divCnt <= '0;
    else if (stb.clear)   divCnt <= '0;
    else if (stb.countEn) divCnt <= divCnt + 1'b1;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : gTap
    assign tapVec[t] = divCnt[tapBit(t)];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tapOut[p] <= 1'b0;
      else if (stb.clear) tapOut[p] <= 1'b0;
      else                tapOut[p] <= tapVec[portSel[p]];
    end
  end

  // R8: disable clears the divider and silences the ports
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clear |=> (divCnt == '0 && tapOut == '0));

  // R2: the divider advances by one on every enabled edge
  assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.countEn && !stb.clear) |=> divCnt == $past(divCnt) + 1'b1);

  // R6: equal selections give equal port waveforms
  assert_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (portSel[0] == portSel[1]) |=> tapOut[0] == tapOut[1]);

endmodule

// File: rtl/divtap_top.sv
module divtap_top
  import divtap_pkg::*;
#(
  parameter int TAP_EXP0 = 4,
  parameter int TAP_EXP1 = 9,
  parameter int TAP_EXP2 = 14,
  parameter int TAP_EXP3 = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] selA,
  input  logic [1:0] selB,
  output logic       primeOut,
  output logic       tapOutA,
  output logic       tapOutB
);

  divStrobe_t                  stb;
  tapSel_t [NUM_PORTS-1:0]     portSel;
  logic    [NUM_PORTS-1:0]     tapOut;

  assign portSel[0] = selA;
  assign portSel[1] = selB;
  assign tapOutA    = tapOut[0];
  assign tapOutB    = tapOut[1];

  divtap_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .stb      (stb),
    .primeOut (primeOut)
  );

  divtap_datapath #(
    .TAP_EXP0 (TAP_EXP0),
    .TAP_EXP1 (TAP_EXP1),
    .TAP_EXP2 (TAP_EXP2),
    .TAP_EXP3 (TAP_EXP3)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .portSel (portSel),
    .tapOut  (tapOut)
  );

endmodule

// File: tb/sim_divtap_top.sv
module sim_divtap_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] selA = 2'b00, selB = 2'b00;
  logic primeOut, tapOutA, tapOutB;
  logic enS = 1'b0;
  logic [1:0] selS = 2'b11;
  logic primeS, tapS, unusedS;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  divtap_top u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .selA(selA), .selB(selB),
    .primeOut(primeOut), .tapOutA(tapOutA), .tapOutB(tapOutB)
  );

  // Shortened top tap so select 11 can be timed in full
  divtap_top #(.TAP_EXP3(6)) u1 (
    .clk(clk), .rst_n(rst_n), .enable(enS), .selA(selS), .selB(2'b00),
    .primeOut(primeS), .tapOutA(tapS), .tapOutB(unusedS)
  );

  // {select, half period}
  localparam int NVEC = 3;
  localparam int VEC_SEL  [NVEC] = '{0, 1, 2};
  localparam int VEC_HALF [NVEC] = '{8, 256, 8192};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Clear and restart u0 with both ports on sel
  task automatic restart(input logic [1:0] sa, input logic [1:0] sb);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    selA = sa;
    selB = sb;
    enable = 1'b1;
  endtask

  // Count leading low, then high, then low samples on port A; also compare B
  task automatic measure(output int lead, output int hi, output int lo,
                         output int mism);
    lead = 0; hi = 0; lo = 0; mism = 0;
    @(negedge clk);
    while (!tapOutA && lead < 300000) begin
      if (tapOutA != tapOutB) mism++;
      lead++; @(negedge clk);
    end
    while (tapOutA && hi < 300000) begin
      if (tapOutA != tapOutB) mism++;
      hi++; @(negedge clk);
    end
    while (!tapOutA && lo < 300000) begin
      if (tapOutA != tapOutB) mism++;
      lo++; @(negedge clk);
    end
  endtask

  task automatic runAll;
    int lead, hi, lo, mism, toggles;
    logic prev;
    // R1: reset state
    #1;
    check("R1 primeOut", int'(primeOut), 0);
    check("R1 tapOutA", int'(tapOutA), 0);
    check("R1 tapOutB", int'(tapOutB), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2, R3, R4 with both ports equal (R6)
    for (int v = 0; v < NVEC; v++) begin
      restart(2'(VEC_SEL[v]), 2'(VEC_SEL[v]));
      measure(lead, hi, lo, mism);
      check($sformatf("R%0s high sel=%0d", v == 0 ? "2" : v == 1 ? "3" : "4", VEC_SEL[v]), hi, VEC_HALF[v]);
      check($sformatf("R%0s low sel=%0d", v == 0 ? "2" : v == 1 ? "3" : "4", VEC_SEL[v]), lo, VEC_HALF[v]);
      check("R6 ports equal", mism, 0);
      if (v == 0) check("R10 lead before first rise", lead, 8);
    end

    // R9: primeOut follows enable one edge later
    enable = 1'b0;
    @(negedge clk);
    check("R9 prime low", int'(primeOut), 0);
    enable = 1'b1;
    #1;
    check("R9 prime not yet", int'(primeOut), 0);
    @(negedge clk);
    check("R9 prime high", int'(primeOut), 1);

    // R8: disabled block holds outputs low and still
    restart(2'b00, 2'b00);
    repeat (12) @(negedge clk);
    enable = 1'b0;
    toggles = 0;
    @(negedge clk);
    prev = tapOutA;
    check("R8 cleared after disable", int'(tapOutA | tapOutB), 0);
    repeat (100) begin
      @(negedge clk);
      if (tapOutA != prev || tapOutB) toggles++;
      prev = tapOutA;
    end
    check("R8 no toggling while disabled", toggles, 0);

    // R7: select change seen at the next edge; independence (R6)
    restart(2'b00, 2'b01);
    repeat (9) @(negedge clk);
    check("R7 A high at sel00", int'(tapOutA), 1);
    check("R6 B independent low", int'(tapOutB), 0);
    selA = 2'b01;
    @(negedge clk);
    check("R7 A follows new select", int'(tapOutA), 0);
    selA = 2'b00;
    @(negedge clk);
    check("R7 A back on sel00", int'(tapOutA), 1);

    // R5: full-size top tap stays low early; scaled instance period
    restart(2'b11, 2'b11);
    toggles = 0;
    repeat (2000) begin
      @(negedge clk);
      if (tapOutA || tapOutB) toggles++;
    end
    check("R5 top tap still low", toggles, 0);
    enS = 1'b1;
    lead = 0; hi = 0; lo = 0;
    @(negedge clk);
    while (!tapS && lead < 1000) begin lead++; @(negedge clk); end
    while (tapS && hi < 1000) begin hi++; @(negedge clk); end
    while (!tapS && lo < 1000) begin lo++; @(negedge clk); end
    check("R5 scaled lead", lead, 32);
    check("R5 scaled high", hi, 32);
    check("R5 scaled low", lo, 32);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule